// File: doc/BRIEF.md
# MDIO Management Register Front End

This block lets software reach the management registers of an Ethernet PHY through two bus-visible registers. A command register holds a PHY address, a PHY register number and a direction bit. A single write to it launches one serial management frame on the MDC/MDIO pins. A data register supplies the 16-bit value for a write, and it receives the 16-bit result of a read.

While a frame is on the wire, a busy bit in the command register reads as 1. Software polls that bit before issuing a command and again afterwards. A read result is valid in the data register once busy has cleared.

The block generates MDC from the system clock with a programmable divider. Each frame has the following fields, in this order:
- a preamble of ones,
- the start pattern `01`,
- the opcode,
- the PHY address and the register number, each MSB first,
- a two-bit turnaround,
- 16 data bits, MSB first.

On a read, the block releases the MDIO line from the turnaround onward and samples the PHY on each rising edge of MDC.

Top module: `mdio_mgmt`

## Requirements
- R1: After reset:
  - the command register reads 0, with busy (bit 15) clear;
  - the data register reads 0;
  - `mdc` and `mdioOe` are low.
- R2: A write to the command register (`regAddr`=0) while idle starts a frame. From the next cycle, a read of the command register returns bit 15 (busy) = 1, together with the written fields: PHY address in bits 4:0, register number in bits 9:5, write-select in bit 10.
- R3: `mdc` is low whenever the block is idle. Each frame produces exactly 64 MDC pulses, and each pulse starts with its low half.
- R4: The 64 bits presented on `mdioOut`, and seen at successive MDC rising edges, are as follows:
  - 32 ones;
  - `01`;
  - the opcode: `10` for a read, `01` for a write;
  - the 5-bit PHY address, MSB first;
  - the 5-bit register number, MSB first.
- R5: On a write (bit 10 = 1), the turnaround is driven as `10`. It is followed by the data register value, MSB first. `mdioOe` is high for all 64 bits.
- R6: On a read (bit 10 = 0):
  - `mdioOe` is high for bits 0 to 45 and low from bit 46 on;
  - `mdioIn` is sampled at the rising MDC edges of bits 48 to 63, MSB first;
  - the 16-bit result appears in the data register once busy clears.
- R7: Busy stays set for exactly 128 × (`mdcHalf`+1) clock cycles per frame. It clears when the high half of the 64th MDC pulse ends.
- R8: A command-register write while busy is ignored. The fields read back unchanged, and the running frame neither restarts nor changes.
- R9: A write to the data register (`regAddr`=1) while idle is read back from the data register unchanged.
- R10: Each MDC half period lasts `mdcHalf`+1 clock cycles, so consecutive rising edges are 2 × (`mdcHalf`+1) cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | 0 = command register, 1 = data register |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Read data for the register selected by `regAddr` (combinational) |
| mdcHalf | input | 8 | MDC half period in clock cycles, minus one |
| mdc | output | 1 | Management clock to the PHY |
| mdioOut | output | 1 | MDIO value driven by the block |
| mdioOe | output | 1 | MDIO output enable (1 = block drives the line) |
| mdioIn | input | 1 | MDIO value from the line |

## Verification
The bench targets the turnaround, where a design that keeps driving during a read contends with the PHY, and the read capture window, where an off-by-one sample shifts the result by one bit. It also targets a command write that arrives mid-frame: a design that accepted it would restart or corrupt the frame and change the fields read back. Busy length is measured exactly under two divider settings. This catches a frame that ends one bit early, or busy dropping before the last high half of MDC.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  // Strobes from the sequencer to the register/shift datapath
  typedef struct packed {
    logic load;       // accept command, build frame
    logic shift;      // advance to next frame bit
    logic capture;    // sample mdioIn into read shifter
    logic latchRead;  // copy read result into data register
  } mdioStrobes_t;

endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int FRAME_LEN = 64,
  parameter int TA_POS    = 46,
  parameter int DATA_POS  = 48,
  parameter int DIV_W     = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             startWrite,
  input  logic [DIV_W-1:0] halfM1,
  output logic             busy,
  output logic             mdc,
  output logic             mdioOe,
  output mdioStrobes_t     strb
);

  localparam int CNT_W = $clog2(FRAME_LEN);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] TA_IDX   = CNT_W'(TA_POS);
  localparam logic [CNT_W-1:0] DATA_IDX = CNT_W'(DATA_POS);

  logic [DIV_W-1:0] divCnt;
  logic             mdcReg;
  logic [CNT_W-1:0] bitIdx;
  logic             wrOp;
  logic             wrap, rising, falling, lastBit;

  always_comb begin
    wrap    = busy && (divCnt >= halfM1);
    rising  = wrap && !mdcReg;
    falling = wrap && mdcReg;
    lastBit = (bitIdx == LAST_IDX);
    strb.load      = startReq && !busy;
    strb.shift     = falling && !lastBit;
    strb.capture   = rising && !wrOp && (bitIdx >= DATA_IDX);
    strb.latchRead = falling && lastBit && !wrOp;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      divCnt <= '0;
      mdcReg <= 1'b0;
      bitIdx <= '0;
      wrOp   <= 1'b0;
    end else if (strb.load) begin
      busy   <= 1'b1;
      divCnt <= '0;
      mdcReg <= 1'b0;
      bitIdx <= '0;
      wrOp   <= startWrite;
    end else if (busy) begin
      if (wrap) begin
        divCnt <= '0;
        mdcReg <= ~mdcReg;
        if (falling) begin
          if (lastBit) busy <= 1'b0;
          else         bitIdx <= bitIdx + 1'b1;
        end
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  assign mdc    = mdcReg;
  assign mdioOe = busy && (wrOp || (bitIdx < TA_IDX));

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && !busy) |=> busy);

  // R3
  idle_mdc_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mdc) |-> $past(busy));

  // R1
  idle_oe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!mdioOe && !mdc));

endmodule

// File: rtl/mdio_datapath.sv
module mdio_datapath
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int PHY_W   = 5,
  parameter int REG_W   = 5,
  parameter int DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              busy,
  input  mdioStrobes_t      strb,
  input  logic              mdioIn,
  output logic              mdioOut,
  output logic              ctrlWr,
  output logic              wrFlag
);

  localparam int FRAME_LEN = PRE_LEN + 4 + PHY_W + REG_W + 2 + DATA_W;
  localparam int WR_BIT    = PHY_W + REG_W;
  localparam int BUSY_BIT  = DATA_W - 1;

  logic [DATA_W-2:0]    ctrlWord;
  logic [DATA_W-1:0]    dataReg;
  logic [DATA_W-1:0]    rdShift;
  logic [FRAME_LEN-1:0] frame;
  logic                 dataWr;

  assign ctrlWr  = regWrEn && !regAddr;
  assign dataWr  = regWrEn && regAddr;
  assign wrFlag  = regWrData[WR_BIT];
  assign mdioOut = frame[FRAME_LEN-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlWord <= '0;
      dataReg  <= '0;
      rdShift  <= '0;
      frame    <= '0;
    end else begin
      if (strb.load) begin
        ctrlWord <= regWrData[DATA_W-2:0];
        frame <= {{PRE_LEN{1'b1}}, 2'b01,
                  (wrFlag ? 2'b01 : 2'b10),
                  regWrData[PHY_W-1:0],
                  regWrData[WR_BIT-1:PHY_W],
                  (wrFlag ? 2'b10 : 2'b11),
                  (wrFlag ? dataReg : {DATA_W{1'b1}})};
      end else if (strb.shift) begin
        frame <= {frame[FRAME_LEN-2:0], 1'b1};
      end
      if (strb.capture)
        rdShift <= {rdShift[DATA_W-2:0], mdioIn};
      if (strb.latchRead)
        dataReg <= rdShift;
      else if (dataWr)
        dataReg <= regWrData;
    end
  end

  always_comb begin
    if (regAddr) regRdData = dataReg;
    else         regRdData = {busy, ctrlWord};
  end

  // R8
  ignored_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && busy) |=> $stable(ctrlWord));

endmodule

// File: rtl/mdio_mgmt.sv
module mdio_mgmt
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int PHY_W   = 5,
  parameter int REG_W   = 5,
  parameter int DATA_W  = 16,
  parameter int DIV_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic [DIV_W-1:0]  mdcHalf,
  output logic              mdc,
  output logic              mdioOut,
  output logic              mdioOe,
  input  logic              mdioIn
);

  localparam int HDR_LEN   = PRE_LEN + 4 + PHY_W + REG_W;
  localparam int FRAME_LEN = HDR_LEN + 2 + DATA_W;

  mdioStrobes_t strb;
  logic busy, ctrlWr, wrFlag;

  mdio_ctrl #(
    .FRAME_LEN(FRAME_LEN),
    .TA_POS   (HDR_LEN),
    .DATA_POS (HDR_LEN + 2),
    .DIV_W    (DIV_W)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .startReq  (ctrlWr),
    .startWrite(wrFlag),
    .halfM1    (mdcHalf),
    .busy      (busy),
    .mdc       (mdc),
    .mdioOe    (mdioOe),
    .strb      (strb)
  );

  mdio_datapath #(
    .PRE_LEN(PRE_LEN),
    .PHY_W  (PHY_W),
    .REG_W  (REG_W),
    .DATA_W (DATA_W)
  ) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .regRdData(regRdData),
    .busy     (busy),
    .strb     (strb),
    .mdioIn   (mdioIn),
    .mdioOut  (mdioOut),
    .ctrlWr   (ctrlWr),
    .wrFlag   (wrFlag)
  );

endmodule

// File: tb/tb_mdio_mgmt.sv
module tb_mdio_mgmt;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regAddr = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic [7:0]  mdcHalf = 8'd1;
  logic        mdc, mdioOut, mdioOe;
  logic        mdioIn = 1'b1;

  int total = 0;
  int failed = 0;
  int cyc = 0;
  int riseCnt = 0;
  int firstRise = -1;
  int secondRise = -1;
  logic [63:0] capOut, capOe;
  logic [15:0] respWord = '0;

  always #5 clk = ~clk;

  mdio_mgmt dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .mdcHalf(mdcHalf),
    .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  always @(posedge clk) cyc++;

  // Line recorder: one entry per MDC rising edge, bit 0 of the frame at [63]
  always @(posedge mdc) begin
    if (riseCnt < 64) begin
      capOut[63-riseCnt] = mdioOut;
      capOe[63-riseCnt]  = mdioOe;
    end
    if (riseCnt == 0) firstRise = cyc;
    if (riseCnt == 1) secondRise = cyc;
    riseCnt++;
  end

  // PHY model: presents the next read-data bit after each MDC falling edge
  always @(negedge mdc) begin
    if (riseCnt >= 48 && riseCnt < 64) mdioIn = respWord[63-riseCnt];
    else mdioIn = 1'b1;
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic a, input logic [15:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regAddr = 1'b0;
  endtask

  task automatic regRead(input logic a, output logic [15:0] d);
    regAddr = a;
    #1 d = regRdData;
    regAddr = 1'b0;
  endtask

  // Launch a frame and count the cycles for which busy reads 1
  task automatic launch(input logic wr, input logic [4:0] phy, input logic [4:0] rg,
                        input logic [7:0] half, output int busyCyc);
    logic [15:0] rd;
    mdcHalf = half;
    riseCnt = 0; firstRise = -1; secondRise = -1;
    regWrite(1'b0, {5'b0, wr, rg, phy});
    regRead(1'b0, rd);
    check(rd == {1'b1, 4'b0, wr, rg, phy}, "R2 busy+fields readback", 64'(rd), 64'({1'b1, 4'b0, wr, rg, phy}));
    busyCyc = 0;
    while (busyCyc < 100000) begin
      regRead(1'b0, rd);
      if (!rd[15]) break;
      busyCyc++;
      @(negedge clk);
    end
  endtask

  task automatic finishChecks(input logic [7:0] half, input int busyCyc);
    check(busyCyc == 128 * (int'(half) + 1), "R7 busy length", 64'(busyCyc), 64'(128 * (int'(half) + 1)));
    check(riseCnt == 64, "R3 pulse count", 64'(riseCnt), 64'd64);
    check(mdc == 1'b0 && mdioOe == 1'b0, "R3 idle mdc/oe", {62'b0, mdc, mdioOe}, 64'd0);
    check(secondRise - firstRise == 2 * (int'(half) + 1), "R10 mdc period",
          64'(secondRise - firstRise), 64'(2 * (int'(half) + 1)));
  endtask

  task automatic testReset();
    logic [15:0] rd;
    regRead(1'b0, rd);
    check(rd == 16'h0, "R1 command reg after reset", 64'(rd), 64'd0);
    regRead(1'b1, rd);
    check(rd == 16'h0, "R1 data reg after reset", 64'(rd), 64'd0);
    check(mdc == 1'b0 && mdioOe == 1'b0, "R1 pins after reset", {62'b0, mdc, mdioOe}, 64'd0);
  endtask

  task automatic testDataReg(input logic [15:0] v);
    logic [15:0] rd;
    regWrite(1'b1, v);
    regRead(1'b1, rd);
    check(rd == v, "R9 data reg readback", 64'(rd), 64'(v));
  endtask

  task automatic testWrite(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] v, input logic [7:0] half);
    int bc;
    logic [63:0] expFrame;
    testDataReg(v);
    launch(1'b1, phy, rg, half, bc);
    expFrame = {32'hFFFF_FFFF, 2'b01, 2'b01, phy, rg, 2'b10, v};
    check(capOut[63:18] == expFrame[63:18], "R4 write header", 64'(capOut[63:18]), 64'(expFrame[63:18]));
    check(capOut[17:0] == expFrame[17:0], "R5 write turnaround+data", 64'(capOut[17:0]), 64'(expFrame[17:0]));
    check(capOe == {64{1'b1}}, "R5 write drives all bits", capOe, {64{1'b1}});
    finishChecks(half, bc);
  endtask

  task automatic testRead(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] resp, input logic [7:0] half);
    int bc;
    logic [15:0] rd;
    logic [45:0] expHdr;
    respWord = resp;
    launch(1'b0, phy, rg, half, bc);
    expHdr = {32'hFFFF_FFFF, 2'b01, 2'b10, phy, rg};
    check(capOut[63:18] == expHdr, "R4 read header", 64'(capOut[63:18]), 64'(expHdr));
    check(capOe == {{46{1'b1}}, 18'b0}, "R6 read release", capOe, {{46{1'b1}}, 18'b0});
    regRead(1'b1, rd);
    check(rd == resp, "R6 read result", 64'(rd), 64'(resp));
    finishChecks(half, bc);
  endtask

  task automatic testBusyIgnore();
    int waitCnt;
    logic [15:0] rd;
    logic [45:0] expHdr;
    respWord = 16'h3C5A;
    mdcHalf = 8'd1;
    riseCnt = 0; firstRise = -1; secondRise = -1;
    regWrite(1'b0, {5'b0, 1'b0, 5'd7, 5'd19});
    repeat (40) @(negedge clk);
    regWrite(1'b0, {5'b0, 1'b1, 5'd2, 5'd4});
    regRead(1'b0, rd);
    check(rd == {1'b1, 4'b0, 1'b0, 5'd7, 5'd19}, "R8 fields unchanged while busy",
          64'(rd), 64'({1'b1, 4'b0, 1'b0, 5'd7, 5'd19}));
    waitCnt = 0;
    while (waitCnt < 100000) begin
      regRead(1'b0, rd);
      if (!rd[15]) break;
      waitCnt++;
      @(negedge clk);
    end
    expHdr = {32'hFFFF_FFFF, 2'b01, 2'b10, 5'd19, 5'd7};
    check(riseCnt == 64, "R8 no restart pulse count", 64'(riseCnt), 64'd64);
    check(capOut[63:18] == expHdr, "R8 frame unchanged", 64'(capOut[63:18]), 64'(expHdr));
    regRead(1'b1, rd);
    check(rd == 16'h3C5A, "R8 read result intact", 64'(rd), 64'h3C5A);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - failed, total);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; failed++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testDataReg(16'hA55A);
    testWrite(5'd1, 5'd0, 16'h8001, 8'd0);
    testWrite(5'd30, 5'd17, 16'h1234, 8'd3);
    testRead(5'd5, 5'd2, 16'hBEEF, 8'd1);
    testRead(5'd31, 5'd31, 16'h0001, 8'd0);
    testBusyIgnore();
    summary();
    $finish;
  end

endmodule